// File: doc/BRIEF.md
# Programmable Measurement Gate Generator

This block turns a free-running reference-clock count into a periodic measurement gate for a frequency counter. Every period starts with a high window of fixed length, 40 ms of reference cycles, and ends with a low window. The length of the low window is chosen so that high plus low together equal the programmed gate time. The gate is meant to drive the capture logic of a counter, and a one-cycle strobe marks each rising edge so that the capture can latch on it.

Software or a neighbouring block supplies two values: the reference frequency in hertz and the gate time in milliseconds. A single-cycle write pulse presents them. The block limits the gate time to a legal window and works out both phase lengths in whole reference cycles. It keeps the result pending until the current low window has run out, so a period that is already in progress is never shortened or stretched.

Each edge of the gate is placed by a comparator. The comparator watches the free-running counter against a compare point, and at every edge the length of the next phase is added to that compare point, modulo 2^32.

Top module: `meas_gate_gen`

## Requirements
- R1: While reset is asserted, gate_o and gate_rise_o are 0. After reset is released, the first rising edge of the gate occurs once the counter has advanced by the high-phase count from its starting value (gate_o is first seen high HIGH+1 clock cycles after release).
- R2: The high phase lasts floor(ref_hz × 40 / 1000) clock cycles.
- R3: One full gate period (high plus low) lasts round(ref_hz × gate_ms / 1000) cycles, and the low phase is that total minus the high count.
- R4: gate_ms values below 50 are treated as 50, and values above 60000 are treated as 60000.
- R5: The rounding in R3 adds one half and then truncates, so a fraction of exactly one half rounds up and anything below one half rounds down.
- R6: A written configuration is held pending. The period in progress completes with its old high and low lengths, and the new lengths take effect starting at the next rising edge. When several writes arrive before that edge, only the last one is used.
- R7: gate_rise_o is high for exactly one cycle per period: the first cycle in which gate_o is high.
- R8: When the free-running counter wraps past 2^32 − 1, the phase lengths do not change.
- R9: gate_o changes only in the cycle after the counter equals the compare point, and it always toggles when that happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; the counter advances once per cycle |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Single-cycle pulse that captures cfg_ref_hz and cfg_gate_ms |
| cfg_ref_hz | input | 32 | Reference frequency in Hz |
| cfg_gate_ms | input | 16 | Requested gate time in milliseconds |
| gate_o | output | 1 | Measurement gate level |
| gate_rise_o | output | 1 | One-cycle pulse on each rising edge of the gate |

## Verification
The assertions assume that every applied configuration gives non-zero high and low counts. This holds when the reference frequency is at least 100 Hz, since 40 ms is then at least four cycles and the clamped 50 ms minimum always leaves at least one low cycle. They also assume that cfg_wr is not raised so late that it races the rising edge it should miss. The stimulus keeps every reference frequency between 100 Hz and a few kHz, so the phases stay short enough to count cycle by cycle. It also issues every write in the first cycle of a high phase, well away from the next rising edge. The counter's starting value is set just below wraparound, so the first full period crosses 2^32.

// File: rtl/meas_gate_pkg.sv
package meas_gate_pkg;

    localparam int CNT_W = 32;

    typedef logic [CNT_W-1:0] cnt_t;

    // Phase lengths in reference cycles
    typedef struct packed {
        cnt_t hi;
        cnt_t lo;
    } phase_cnts_t;

    // Configuration holding state
    typedef struct packed {
        logic        pend;
        phase_cnts_t pend_cnts;
        phase_cnts_t act_cnts;
    } hold_st_t;

    // Edge scheduler state
    typedef struct packed {
        cnt_t cnt;
        cnt_t cmp;
        logic gate;
        logic strobe;
    } sched_st_t;

endpackage

// File: rtl/gate_cnt_calc.sv
module gate_cnt_calc
    import meas_gate_pkg::*;
#(
    parameter int REF_W   = 32,
    parameter int MS_W    = 16,
    parameter int HIGH_MS = 40,
    parameter int MS_MIN  = 50,
    parameter int MS_MAX  = 60000
) (
    input  logic [REF_W-1:0] ref_hz,
    input  logic [MS_W-1:0]  gate_ms,
    output phase_cnts_t      cnts
);

    localparam int PW = REF_W + MS_W;

    logic [MS_W-1:0] ms_clamped;
    logic [PW-1:0]   prod_total;
    logic [PW-1:0]   prod_high;
    logic [PW:0]     total_rnd;
    cnt_t            total_cyc;
    cnt_t            high_cyc;

    always_comb begin
        // R4: keep the gate time inside its legal window
        if (gate_ms < MS_W'(MS_MIN)) begin
            ms_clamped = MS_W'(MS_MIN);
        end else if (gate_ms > MS_W'(MS_MAX)) begin
            ms_clamped = MS_W'(MS_MAX);
        end else begin
            ms_clamped = gate_ms;
        end

        prod_total = PW'(ref_hz) * PW'(ms_clamped);
        prod_high  = PW'(ref_hz) * PW'(HIGH_MS);

        // R5: add one half (500 of 1000) before truncation
        total_rnd  = ({1'b0, prod_total} + (PW+1)'(500)) / (PW+1)'(1000);
        total_cyc  = CNT_W'(total_rnd);
        high_cyc   = CNT_W'(prod_high / PW'(1000));

        cnts.hi    = high_cyc;
        cnts.lo    = total_cyc - high_cyc;
    end

endmodule

// File: rtl/gate_cfg_hold.sv
module gate_cfg_hold
    import meas_gate_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  phase_cnts_t wr_cnts,
    input  phase_cnts_t init_cnts,
    input  logic        apply,
    output phase_cnts_t nxt_cnts,
    output phase_cnts_t act_cnts,
    output logic        pend_o
);

    hold_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        nxt_cnts = st_q.pend ? st_q.pend_cnts : st_q.act_cnts;

        if (apply) begin
            st_d.act_cnts = nxt_cnts;
            st_d.pend     = 1'b0;
        end
        if (wr) begin
            st_d.pend      = 1'b1;
            st_d.pend_cnts = wr_cnts;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.pend      <= 1'b0;
            st_q.pend_cnts <= init_cnts;
            st_q.act_cnts  <= init_cnts;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_cnts = st_q.act_cnts;
    assign pend_o   = st_q.pend;

    AST_ACT_HELD: assert property (@(posedge clk) disable iff (rst)
        !apply |=> $stable(act_cnts)) else $error("active counts moved without apply"); // R6

    AST_WR_PENDS: assert property (@(posedge clk) disable iff (rst)
        wr |=> pend_o) else $error("write not held pending"); // R6

    AST_APPLY_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (apply && !wr) |=> !pend_o) else $error("pending not cleared on apply"); // R6

endmodule

// File: rtl/gate_edge_sched.sv
module gate_edge_sched
    import meas_gate_pkg::*;
#(
    parameter cnt_t CNT_START = '0
) (
    input  logic clk,
    input  logic rst,
    input  cnt_t init_hi,
    input  cnt_t nxt_hi,
    input  cnt_t act_lo,
    output logic apply,
    output logic gate_o,
    output logic strobe_o
);

    sched_st_t st_d, st_q;
    logic      hit;

    always_comb begin
        st_d        = st_q;
        st_d.cnt    = st_q.cnt + 1'b1;   // modulo 2^CNT_W
        st_d.strobe = 1'b0;
        hit         = (st_q.cnt == st_q.cmp);
        apply       = hit && !st_q.gate;

        if (hit) begin
            st_d.gate = !st_q.gate;
            if (!st_q.gate) begin
                st_d.cmp    = st_q.cmp + nxt_hi;
                st_d.strobe = 1'b1;
            end else begin
                st_d.cmp    = st_q.cmp + act_lo;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt    <= CNT_START;
            st_q.cmp    <= CNT_START + init_hi;
            st_q.gate   <= 1'b0;
            st_q.strobe <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_o   = st_q.gate;
    assign strobe_o = st_q.strobe;

    AST_TOGGLE_ON_HIT: assert property (@(posedge clk) disable iff (rst)
        hit |=> (gate_o != $past(gate_o))) else $error("gate missed a compare"); // R9

    AST_HOLD_OFF_HIT: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(gate_o)) else $error("gate moved off compare"); // R9

    AST_STROBE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        strobe_o |-> (gate_o && !$past(gate_o))) else $error("strobe not on rise"); // R7

    AST_RISE_HAS_STROBE: assert property (@(posedge clk) disable iff (rst)
        (gate_o && !$past(gate_o)) |-> strobe_o) else $error("rise without strobe"); // R7

endmodule

// File: rtl/meas_gate_gen.sv
module meas_gate_gen
    import meas_gate_pkg::*;
#(
    parameter int   REF_W       = 32,
    parameter int   MS_W        = 16,
    parameter int   HIGH_MS     = 40,
    parameter int   MS_MIN      = 50,
    parameter int   MS_MAX      = 60000,
    parameter int   DEF_REF_HZ  = 100_000_000,
    parameter int   DEF_GATE_MS = 1000,
    parameter cnt_t CNT_START   = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [REF_W-1:0] cfg_ref_hz,
    input  logic [MS_W-1:0]  cfg_gate_ms,
    output logic             gate_o,
    output logic             gate_rise_o
);

    phase_cnts_t wr_cnts;
    phase_cnts_t init_cnts;
    phase_cnts_t nxt_cnts;
    phase_cnts_t act_cnts;
    logic        apply;
    logic        pend;

    // Counts for the written configuration
    gate_cnt_calc #(
        .REF_W(REF_W), .MS_W(MS_W), .HIGH_MS(HIGH_MS),
        .MS_MIN(MS_MIN), .MS_MAX(MS_MAX)
    ) u_calc_wr (
        .ref_hz (cfg_ref_hz),
        .gate_ms(cfg_gate_ms),
        .cnts   (wr_cnts)
    );

    // Counts used out of reset, from constant parameters
    gate_cnt_calc #(
        .REF_W(REF_W), .MS_W(MS_W), .HIGH_MS(HIGH_MS),
        .MS_MIN(MS_MIN), .MS_MAX(MS_MAX)
    ) u_calc_init (
        .ref_hz (REF_W'(DEF_REF_HZ)),
        .gate_ms(MS_W'(DEF_GATE_MS)),
        .cnts   (init_cnts)
    );

    gate_cfg_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .wr       (cfg_wr),
        .wr_cnts  (wr_cnts),
        .init_cnts(init_cnts),
        .apply    (apply),
        .nxt_cnts (nxt_cnts),
        .act_cnts (act_cnts),
        .pend_o   (pend)
    );

    gate_edge_sched #(
        .CNT_START(CNT_START)
    ) u_sched (
        .clk     (clk),
        .rst     (rst),
        .init_hi (init_cnts.hi),
        .nxt_hi  (nxt_cnts.hi),
        .act_lo  (act_cnts.lo),
        .apply   (apply),
        .gate_o  (gate_o),
        .strobe_o(gate_rise_o)
    );

    AST_APPLIED_NONZERO: assert property (@(posedge clk) disable iff (rst)
        apply |-> (nxt_cnts.hi != '0 && nxt_cnts.lo != '0)) else $error("zero phase length applied"); // R3

    AST_PEND_UNTIL_RISE: assert property (@(posedge clk) disable iff (rst)
        (pend && !apply && !cfg_wr) |=> pend) else $error("pending dropped before rise"); // R6

endmodule

// File: tb/meas_gate_gen_bench.sv
module meas_gate_gen_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_ref_hz = '0;
    logic [15:0] cfg_gate_ms = '0;
    logic        gate_o;
    logic        gate_rise_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    meas_gate_gen #(
        .DEF_REF_HZ (1000),
        .DEF_GATE_MS(100),
        .CNT_START  (32'hFFFF_FF80)
    ) u_meas_gate_gen (
        .clk        (clk),
        .rst        (rst),
        .cfg_wr     (cfg_wr),
        .cfg_ref_hz (cfg_ref_hz),
        .cfg_gate_ms(cfg_gate_ms),
        .gate_o     (gate_o),
        .gate_rise_o(gate_rise_o)
    );

    typedef struct packed {
        logic [31:0] ref_hz;
        logic [15:0] ms;
        logic [31:0] exp_hi;
        logic [31:0] exp_lo;
    } vec_t;

    // v0: R4 lower clamp, v1: R4 upper clamp, v2: R5 exact half rounds up,
    // v3: R5 below half rounds down, v4: R3 general, v5: R2 fractional high
    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{32'd1000, 16'd10,    32'd40,  32'd10},
        '{32'd100,  16'd65000, 32'd4,   32'd5996},
        '{32'd1010, 16'd50,    32'd40,  32'd11},
        '{32'd1009, 16'd50,    32'd40,  32'd10},
        '{32'd2500, 16'd123,   32'd100, 32'd208},
        '{32'd1030, 16'd50,    32'd41,  32'd11}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Entry and exit at a falling edge where the gate has just risen.
    task automatic run_period(input int nwr,
                              input logic [31:0] r1, input logic [15:0] m1,
                              input logic [31:0] r2, input logic [15:0] m2,
                              output int hi, output int lo, output int st);
        hi = 0; lo = 0; st = 0;
        if (nwr >= 1) begin
            cfg_wr = 1'b1; cfg_ref_hz = r1; cfg_gate_ms = m1;
        end
        while (gate_o) begin
            hi++;
            st += int'(gate_rise_o);
            @(negedge clk);
            if (hi == 1 && nwr == 2) begin
                cfg_ref_hz = r2; cfg_gate_ms = m2;
            end else begin
                cfg_wr = 1'b0;
            end
        end
        while (!gate_o) begin
            lo++;
            st += int'(gate_rise_o);
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        int hi, lo, st, n;
        int prev_hi, prev_lo;

        repeat (3) @(negedge clk);
        chk(gate_o == 1'b0, "R1", "gate in reset", gate_o, 0);
        chk(gate_rise_o == 1'b0, "R1", "strobe in reset", gate_rise_o, 0);

        rst = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!gate_o && n < 1000);
        chk(n == 41, "R1", "cycles to first rise", n, 41);
        chk(gate_rise_o == 1'b1, "R7", "strobe at first rise", gate_rise_o, 1);

        // first period crosses counter wraparound (R8)
        run_period(0, 0, 0, 0, 0, hi, lo, st);
        chk(hi == 40, "R8", "high across wrap", hi, 40);
        chk(lo == 60, "R8", "low across wrap", lo, 60);
        chk(st == 1, "R7", "strobes per period", st, 1);
        prev_hi = 40; prev_lo = 60;

        for (int i = 0; i < NV; i++) begin
            // R6: write is pending; current period keeps old lengths
            run_period(1, VECS[i].ref_hz, VECS[i].ms, 0, 0, hi, lo, st);
            chk(hi == prev_hi, "R6", "high while pending", hi, prev_hi);
            chk(lo == prev_lo, "R6", "low while pending", lo, prev_lo);
            chk(gate_rise_o == 1'b1, "R7", "strobe at rise", gate_rise_o, 1);
            // new lengths (R2 high, R3 low; R4/R5 per table comment)
            run_period(0, 0, 0, 0, 0, hi, lo, st);
            chk(hi == int'(VECS[i].exp_hi), "R2", "high length", hi, VECS[i].exp_hi);
            chk(lo == int'(VECS[i].exp_lo), "R3", "low length", lo, VECS[i].exp_lo);
            chk(st == 1, "R7", "strobes per period", st, 1);
            prev_hi = int'(VECS[i].exp_hi);
            prev_lo = int'(VECS[i].exp_lo);
        end

        // R6: two writes before the rise, the last one wins
        run_period(2, 32'd1000, 16'd200, 32'd1000, 16'd80, hi, lo, st);
        chk(hi == prev_hi, "R6", "high with two writes pending", hi, prev_hi);
        chk(lo == prev_lo, "R6", "low with two writes pending", lo, prev_lo);
        run_period(0, 0, 0, 0, 0, hi, lo, st);
        chk(hi == 40, "R6", "high after last write", hi, 40);
        chk(lo == 40, "R6", "low after last write", lo, 40);

        // R9: steady state repeats without configuration
        run_period(0, 0, 0, 0, 0, hi, lo, st);
        chk(hi == 40 && lo == 40, "R9", "repeat period total", hi + lo, 80);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule